// File: doc/BRIEF.md
# Element-Width Packed Register Access Unit

This block holds a file of 64-bit registers and gives a vector datapath access to it by element rather than by register. When a narrower element width is in force, the registers starting at a chosen base are seen as one unbroken little-endian byte array. Element `i` of width `w` bits sits at byte `i*w/8` of that array, so 8-, 16- and 32-bit elements are packed several to a register and run on into the following registers. A 64-bit width gives one element per register.

Each accepted request is either a read or a write of one element. A read returns the element zero-extended to 64 bits. A write places the low `w` bits of the write data into exactly the bytes of that element. It leaves every other bit of the register file as it was. Carries and upper bits of the write data never spill into a neighbouring element. An element whose register would lie past the last register is refused with an error flag.

The control is a two-state machine. In `ST_IDLE` the block accepts a request (transition *accept*, taken when `req_valid` is high). The write, if any, commits at that edge, and the read data is captured at the same edge. The machine then moves to `ST_RESP`. In `ST_RESP` the response is presented for exactly one cycle, and the machine always returns to `ST_IDLE` (transition *retire*). Requests seen in `ST_RESP` are not taken.

Top module: `ewpk_access`

## Requirements
- R1: After reset every register holds zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The width code on `req_width` selects 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Element `i` lies in register `base + (i*w)/64`, starting at bit `(i*w) mod 64`. At 8 bits, element 0 is bits 7:0 and element 1 is bits 15:8 of the base register.
- R3: A write changes only the bytes of its element and preserves all other bits. `rsp_byte_en` bit k is set exactly when byte k (bits 8k+7:8k) of the addressed register belongs to the element. It shows `1 << req_width` set bits for any request that is not in error.
- R4: A read returns the element zero-extended to 64 bits on `rsp_rdata`. For a write, `rsp_rdata` is 0.
- R5: At 32 bits, elements 0 and 1 fill the low and high halves of the base register. Element 2 fills the low half of base+1 and leaves its high half unchanged.
- R6: At 64 bits, element `i` is the whole of register `base+i`. This is used to store full-width results of narrow sources, one register per element.
- R7: When the computed register number exceeds 31, `rsp_error` is 1, no register changes, and `rsp_byte_en` and `rsp_rdata` are 0.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1. The response (`rsp_valid` = 1) follows in the next cycle and lasts one cycle. During that cycle `req_ready` is 0.
- R9: Bits of `req_wdata` above the element width are ignored. An 8-bit write of 0x11f stores 0x1f and leaves the next element untouched.
- R10: A request presented while `req_ready` is 0 is ignored: it writes nothing and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write element, 0 = read element |
| req_base | input | 5 | Base register number |
| req_index | input | 6 | Element index |
| req_width | input | 2 | Element width code (R2) |
| req_wdata | input | 64 | Write data, low bits used |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Zero-extended read element |
| rsp_error | output | 1 | Register number out of range |
| rsp_byte_en | output | 8 | Bytes of the addressed register covered by the element |

## Verification
The assertions check these properties on every cycle:
- the one-cycle response that follows each accepted request, and the single-cycle length of the response;
- the number of enabled bytes, which must match the width;
- the zero upper bits of narrow reads;
- the silence of the mask and data on an error.

Only the bench's scenarios can show the remaining behaviour. This covers where an element actually lands: packing across register boundaries, and the preservation of neighbouring bytes after partial writes. It also covers the discarding of high write-data bits, the absence of any write on an out-of-range element, and the ignoring of requests during the response cycle. The bench shows these by reading the registers back through the same port and comparing them with its own byte-level model.

// File: rtl/ewpk_pkg.sv
package ewpk_pkg;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_code_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_t;

endpackage

// File: rtl/ewpk_lane_map.sv
module ewpk_lane_map
    import ewpk_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int IDXW  = 6,
    parameter int REGW  = 64
) (
    input  logic [$clog2(NREGS)-1:0]        base,
    input  logic [IDXW-1:0]                 index,
    input  logic [1:0]                      width,
    output logic [$clog2(NREGS)-1:0]        reg_idx,
    output logic [$clog2(REGW/8)-1:0]       byte_off,
    output logic [REGW/8-1:0]               byte_mask,
    output logic                            out_of_range
);
    localparam int RIDXW = $clog2(NREGS);
    localparam int NBYTE = REGW / 8;
    localparam int BOFFW = $clog2(NBYTE);
    localparam int LINW  = IDXW + BOFFW;
    localparam int SUMW  = ((IDXW > RIDXW) ? IDXW : RIDXW) + 1;

    logic [LINW-1:0]  lin_byte;
    logic [IDXW-1:0]  reg_step;
    logic [SUMW-1:0]  reg_sum;
    logic [NBYTE-1:0] elem_mask;

    // byte position of the element within the packed array
    always_comb begin
        lin_byte = LINW'(index) << width;
        reg_step = lin_byte[LINW-1:BOFFW];
        byte_off = lin_byte[BOFFW-1:0];
        reg_sum  = SUMW'(base) + SUMW'(reg_step);
        out_of_range = (reg_sum >= SUMW'(NREGS));
        reg_idx  = reg_sum[RIDXW-1:0];
    end

    always_comb begin
        elem_mask = '0;
        for (int b = 0; b < NBYTE; b++) begin
            if (b < (1 << width)) elem_mask[b] = 1'b1;
        end
        byte_mask = out_of_range ? '0 : (elem_mask << byte_off);
    end

endmodule

// File: rtl/ewpk_lane_align.sv
module ewpk_lane_align
    import ewpk_pkg::*;
#(
    parameter int REGW = 64
) (
    input  logic [1:0]                width,
    input  logic [$clog2(REGW/8)-1:0] byte_off,
    input  logic [REGW-1:0]           wdata,
    input  logic [REGW-1:0]           rword,
    output logic [REGW-1:0]           wword,
    output logic [REGW-1:0]           rdata_ext
);
    localparam int NBYTE = REGW / 8;
    localparam int BOFFW = $clog2(NBYTE);
    localparam int SHW   = BOFFW + 3;

    logic [REGW-1:0] keep;
    logic [SHW-1:0]  bit_off;

    // width keep mask, built byte by byte
    generate
        for (genvar b = 0; b < NBYTE; b++) begin : g_keep
            assign keep[8*b +: 8] = (b < (1 << width)) ? 8'hFF : 8'h00;
        end
    endgenerate

    always_comb begin
        bit_off   = {byte_off, 3'b000};
        wword     = (wdata & keep) << bit_off;
        rdata_ext = (rword >> bit_off) & keep;
    end

endmodule

// File: rtl/ewpk_regfile.sv
module ewpk_regfile #(
    parameter int NREGS = 32,
    parameter int REGW  = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NREGS)-1:0]  wr_idx,
    input  logic [REGW/8-1:0]         wr_be,
    input  logic [REGW-1:0]           wr_word,
    input  logic [$clog2(NREGS)-1:0]  rd_idx,
    output logic [REGW-1:0]           rd_word
);
    localparam int NBYTE = REGW / 8;

    logic [REGW-1:0] regs [NREGS];

    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_reg
            for (genvar b = 0; b < NBYTE; b++) begin : g_byte
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        regs[r][8*b +: 8] <= 8'h00;
                    end else if (wr_en && (wr_idx == r) && wr_be[b]) begin
                        regs[r][8*b +: 8] <= wr_word[8*b +: 8];
                    end
                end
            end
        end
    endgenerate

    assign rd_word = regs[rd_idx];

endmodule

// File: rtl/ewpk_access.sv
module ewpk_access
    import ewpk_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int IDXW  = 6,
    parameter int REGW  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [$clog2(NREGS)-1:0]   req_base,
    input  logic [IDXW-1:0]            req_index,
    input  logic [1:0]                 req_width,
    input  logic [REGW-1:0]            req_wdata,
    output logic                       req_ready,
    output logic                       rsp_valid,
    output logic [REGW-1:0]            rsp_rdata,
    output logic                       rsp_error,
    output logic [REGW/8-1:0]          rsp_byte_en
);
    localparam int RIDXW = $clog2(NREGS);
    localparam int NBYTE = REGW / 8;
    localparam int BOFFW = $clog2(NBYTE);

    acc_state_t state_q, state_d;

    logic [RIDXW-1:0] map_reg;
    logic [BOFFW-1:0] map_off;
    logic [NBYTE-1:0] map_mask;
    logic             map_oor;
    logic [REGW-1:0]  al_wword, al_rext, rf_rword;
    logic             accept, rf_wen;

    logic [REGW-1:0]  rdata_q;
    logic             err_q;
    logic [NBYTE-1:0] be_q;
    logic [1:0]       wid_q;

    ewpk_lane_map #(.NREGS(NREGS), .IDXW(IDXW), .REGW(REGW)) u_map (
        .base(req_base), .index(req_index), .width(req_width),
        .reg_idx(map_reg), .byte_off(map_off), .byte_mask(map_mask),
        .out_of_range(map_oor)
    );

    ewpk_lane_align #(.REGW(REGW)) u_align (
        .width(req_width), .byte_off(map_off), .wdata(req_wdata),
        .rword(rf_rword), .wword(al_wword), .rdata_ext(al_rext)
    );

    ewpk_regfile #(.NREGS(NREGS), .REGW(REGW)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_wen), .wr_idx(map_reg),
        .wr_be(map_mask), .wr_word(al_wword), .rd_idx(map_reg),
        .rd_word(rf_rword)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign rf_wen = accept && req_write && !map_oor;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;   // accept
            ST_RESP: state_d = ST_IDLE;                  // retire
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            err_q   <= 1'b0;
            be_q    <= '0;
            wid_q   <= 2'd0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rdata_q <= (req_write || map_oor) ? '0 : al_rext;
                err_q   <= map_oor;
                be_q    <= map_mask;
                wid_q   <= req_width;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
        rsp_rdata   = rdata_q;
        rsp_error   = err_q;
        rsp_byte_en = be_q;
    end

    a_r8_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    a_r8_resp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_error_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> (rsp_byte_en == '0 && rsp_rdata == '0));

    a_r3_mask_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_error) |-> ($countones(rsp_byte_en) == (1 << wid_q)));

    a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && wid_q != EW_64) |-> ((rsp_rdata >> (8 << wid_q)) == '0));

endmodule

// File: tb/test_ewpk_access.sv
module test_ewpk_access;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_base = '0;
    logic [5:0]  req_index = '0;
    logic [1:0]  req_width = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_error;
    logic [63:0] rsp_rdata;
    logic [7:0]  rsp_byte_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] model [32];

    always #10 clk = ~clk;  // 50 MHz

    ewpk_access i_ewpk_access (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_base(req_base), .req_index(req_index), .req_width(req_width),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .rsp_byte_en(rsp_byte_en)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request; expectations from the element layout rules (R2)
    task automatic access(input string tag, input logic wr, input int base,
                          input int idx, input int wcode, input logic [63:0] data);
        int bytes = 1 << wcode;
        int lin   = idx * bytes;
        int rg    = base + lin / 8;
        int off   = lin % 8;
        logic        exp_err = (rg > 31);
        logic [7:0]  exp_be = '0;
        logic [63:0] exp_rd = '0;
        if (!exp_err) begin
            for (int b = 0; b < bytes; b++) begin
                exp_be[off + b] = 1'b1;
                if (wr) model[rg][8*(off+b) +: 8] = data[8*b +: 8];
                else    exp_rd[8*b +: 8] = model[rg][8*(off+b) +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_base = 5'(base);
        req_index = 6'(idx); req_width = 2'(wcode); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R8 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " R7 rsp_error"}, 64'(rsp_error), 64'(exp_err));
        check({tag, " R3 byte_en"}, 64'(rsp_byte_en), 64'(exp_be));
        check({tag, " R4 rdata"}, rsp_rdata, exp_rd);
    endtask

    task automatic read_reg(input string tag, input int r);
        access(tag, 1'b0, r, 0, 3, 64'd0);
    endtask

    task automatic t_reset;
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 no response after reset", 64'(rsp_valid), 64'd0);
        read_reg("R1 reg5 zero", 5);
        read_reg("R1 reg31 zero", 31);
    endtask

    task automatic t_ew8_pack;
        access("R9 ew8 e0 carry dropped", 1'b1, 1, 0, 0, 64'h20 + 64'hff);
        access("R2 ew8 e1", 1'b1, 1, 1, 0, 64'h12 + 64'h43);
        read_reg("R2 R9 reg1 packed", 1);
        check("R2 reg1 value 0x551f", model[1], 64'h551f);
        access("R4 ew8 read e1", 1'b0, 1, 1, 0, 64'd0);
    endtask

    task automatic t_ew32;
        access("R6 preload reg2", 1'b1, 2, 0, 3, 64'h0000_0001_0000_0002);
        access("R5 ew32 e0", 1'b1, 1, 0, 2, 64'h1000_1000_f000_1220 + 64'h8000_43ff);
        access("R5 ew32 e1", 1'b1, 1, 1, 2, 64'h0000_0000_1000_1000);
        access("R5 ew32 e2", 1'b1, 1, 2, 2, 64'h8000_1111 + 64'h2223);
        read_reg("R5 reg1 full", 1);
        read_reg("R5 reg2 high kept", 2);
        check("R5 reg2 value", model[2], 64'h0000_0001_8000_3334);
    endtask

    task automatic t_ew16_cross;
        access("R3 preload reg11", 1'b1, 11, 0, 3, 64'hffff_eeee_dddd_cccc);
        access("R3 ew16 e5 into reg11", 1'b1, 10, 5, 1, 64'hdead_5a5a);
        read_reg("R3 reg11 neighbours kept", 11);
        check("R3 reg11 value", model[11], 64'hffff_eeee_5a5a_cccc);
        access("R4 ew8 e9 read", 1'b0, 10, 9, 0, 64'd0);
        access("R4 ew16 e7 read", 1'b0, 10, 7, 1, 64'd0);
    endtask

    task automatic t_src8_full_dest;
        access("R6 src packed", 1'b1, 20, 0, 3, 64'h1220);
        access("R6 src packed b", 1'b1, 21, 0, 3, 64'h43ff);
        access("R6 src e0 read", 1'b0, 20, 0, 0, 64'd0);
        access("R6 dst e0", 1'b1, 24, 0, 3, 64'h20 + 64'hff);
        access("R6 dst e1", 1'b1, 24, 1, 3, 64'h12 + 64'h43);
        read_reg("R6 reg24", 24);
        read_reg("R6 reg25", 25);
        check("R6 reg24 value", model[24], 64'h11f);
    endtask

    task automatic t_range;
        access("R3 preload reg31", 1'b1, 31, 0, 3, 64'h0123_4567_89ab_cdef);
        access("R7 ew64 past end", 1'b1, 31, 1, 3, 64'hbad0);
        access("R7 ew8 past end", 1'b1, 30, 16, 0, 64'hbb);
        access("R7 read past end", 1'b0, 28, 63, 2, 64'd0);
        read_reg("R7 reg31 kept", 31);
        read_reg("R7 reg0 kept", 0);
        read_reg("R7 reg30 kept", 30);
    endtask

    task automatic t_busy;
        access("R10 preload reg7", 1'b1, 7, 0, 3, 64'h77);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_base = 5'd7;
        req_index = 6'd0; req_width = 2'd3; req_wdata = 64'h1111;
        model[7] = 64'h1111;
        @(negedge clk);
        check("R10 ready low in response", 64'(req_ready), 64'd0);
        req_wdata = 64'h2222;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 no second response", 64'(rsp_valid), 64'd0);
        read_reg("R10 reg7 first write only", 7);
    endtask

    initial begin
        for (int r = 0; r < 32; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ew8_pack();
        t_ew32();
        t_ew16_cross();
        t_src8_full_dest();
        t_range();
        t_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule